// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing side of a minimal serial port. A 32-bit bus slave exposes three word registers: a data word, a control/status word and a clock word. It holds a single transmit byte and a single receive byte. It has no queueing, no DMA and no interrupt line. Both directions are driven through two flag bits in the data word. Software writes the transmit flag to hand a byte to the transmit shifter. It writes the receive flag to release a byte that the receive shifter has delivered.

The control/status word carries a two-bit interface-mode field and two ready-override bits. The override bits force the transmit and receive handshakes active whatever the flow-control state is. It also carries a sticky overrun bit. The clock word is only stored and exported to a separate baud generator. The shifters sit outside this block. They see a one-cycle start pulse with the byte, a done pulse back, and a byte-valid pulse with the received byte.

Top module: `uart_regif`

## Requirements
- R1: After reset, the data word reads 0x200 (transmit-ready set, nothing received). The control/status and clock words read 0. The start pulse is low.
- R2: A data-word read returns the held receive byte in bits [7:0], the receive-valid flag in bit 8 and the transmit-ready flag in bit 9. All other bits read 0.
- R3: A data write with bit 9 set while transmit-ready is 1 raises `tx_start` for exactly the next cycle, with `tx_byte` equal to the written bits [7:0]. Transmit-ready then reads 0 until a `tx_done` pulse.
- R4: A data write with bit 9 set while transmit-ready is 0 is ignored. No start pulse is issued and `tx_byte` keeps its value.
- R5: A `rx_valid` pulse stores `rx_byte` and sets the receive-valid flag from the next cycle.
- R6: A data write with bit 8 set clears the receive-valid flag and does not alter the held byte.
- R7: If a byte arrives while the receive-valid flag is set and no acknowledge happens in the same cycle, the new byte replaces the old one and overrun bit 12 of the control/status word becomes 1. The bit stays set until software writes a 1 to it. Setting takes priority over clearing.
- R8: A data write with bits 8 and 9 both 0 changes nothing.
- R9: Control/status bits [3:2] hold the interface mode (1 selects DTE, 2 selects DCE) and drive `if_mode`. Bit 7 is the transmit override and bit 8 is the receive override. Both read back.
- R10: `tx_enable` is the transmit override OR `cts_in`. `rx_ready` is the receive override OR NOT receive-valid.
- R11: The clock word stores all 32 written bits, reads them back and drives `clk_cfg`.
- R12: Reads of any offset other than 0x00, 0x04 and 0x08 return 0, and writes to them change nothing. `bus_rdata` is 0 unless a read is being presented.
- R13: An arrival in the same cycle as an acknowledge leaves the new byte held, the flag at 1 and no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tx_start | output | 1 | One-cycle pulse: send `tx_byte` |
| tx_byte | output | 8 | Byte for the transmit shifter |
| tx_done | input | 1 | Pulse: transmit shifter free again |
| rx_valid | input | 1 | Pulse: received byte present |
| rx_byte | input | 8 | Received byte |
| cts_in | input | 1 | Peer allows sending |
| tx_enable | output | 1 | Transmit handshake after override |
| rx_ready | output | 1 | Receive handshake after override |
| if_mode | output | 2 | Interface-mode field |
| clk_cfg | output | 32 | Clock word for the baud generator |

## Verification
Directed sequences cover the cases the flags have to tell apart. One is a launch followed by a launch attempt while busy, which separates an accepted byte from an ignored one. Another is arrival, an all-zero write and then an acknowledge, which separates a no-op write from a consuming one. Back-to-back arrivals without an acknowledge, and an arrival in the same cycle as an acknowledge, separate a true overrun from a replacement that was acknowledged. After these, a long pseudo-random mix of reads and writes to valid and undefined offsets runs together with random done, arrival and clear-to-send pulses. It shows that the flags, overrides and stored words stay consistent under interleavings the directed cases do not reach.

// File: rtl/uart_regif_pkg.sv
// Package: register offsets and bit positions shared by the UART register front end.
package uart_regif_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int OFS_DATA   = 'h00;
    localparam int OFS_CTRL   = 'h04;
    localparam int OFS_CLK    = 'h08;
    localparam int RXF_BIT    = 8;
    localparam int TXR_BIT    = 9;
    localparam int MODE_LO    = 2;
    localparam int MODE_W     = 2;
    localparam int TXOVR_BIT  = 7;
    localparam int RXOVR_BIT  = 8;
    localparam int OVRUN_BIT  = 12;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_CLK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              tx_ovr;
        logic              rx_ovr;
    } ctrl_t;
endpackage

// File: rtl/uart_regif_txctl.sv
// Module: transmit handshake. Holds the byte to send and the busy state.
// Assumes the shifter answers each start pulse with exactly one done pulse.
module uart_regif_txctl #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ready_o
);
    logic busy_q;
    logic accept;

    // Accept a launch only while the shifter is idle.
    assign accept  = launch_i & ~busy_q;
    assign ready_o = ~busy_q;

    // Busy flag, start pulse and held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_o <= 1'b0;
            byte_o  <= '0;
        end else begin
            start_o <= accept;
            if (accept) begin
                busy_q <= 1'b1;
                byte_o <= byte_i;
            end else if (done_i) begin
                busy_q <= 1'b0;
            end
        end
    end

    AST_TX_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_q); // R3
    AST_TX_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_o) |-> $stable(byte_o)); // R4
endmodule

// File: rtl/uart_regif_rxhold.sv
// Module: receive holding byte with valid flag and sticky overrun.
// Assumes at most one arrival pulse per cycle; arrival beats acknowledge.
module uart_regif_rxhold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ack_i,
    input  logic              ovr_clr_i,
    output logic              full_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ovr_o
);
    logic lost;

    // A byte is lost when one is still unread and not being released.
    assign lost = arrive_i & full_o & ~ack_i;

    // Valid flag and held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            byte_o <= '0;
        end else if (arrive_i) begin
            full_o <= 1'b1;
            byte_o <= byte_i;
        end else if (ack_i) begin
            full_o <= 1'b0;
        end
    end

    // Sticky overrun, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_o <= 1'b0;
        else if (lost)
            ovr_o <= 1'b1;
        else if (ovr_clr_i)
            ovr_o <= 1'b0;
    end

    AST_RX_FLAG_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_i |=> full_o); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !ovr_clr_i) |=> ovr_o); // R7
    AST_ACK_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !arrive_i) |=> $stable(byte_o)); // R6
endmodule

// File: rtl/uart_regif_csr.sv
// Module: control/status fields and the clock word.
// Assumes write strobes are already decoded; overrun lives in the receive path.
module uart_regif_csr
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_clk_i,
    input  logic [WORD_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [WORD_W-1:0] clk_cfg_o
);
    // Mode and override fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_ctrl_i) begin
            ctrl_o.mode   <= wdata_i[MODE_LO +: MODE_W];
            ctrl_o.tx_ovr <= wdata_i[TXOVR_BIT];
            ctrl_o.rx_ovr <= wdata_i[RXOVR_BIT];
        end
    end

    // Clock word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_cfg_o <= '0;
        else if (wr_clk_i)
            clk_cfg_o <= wdata_i;
    end

    AST_CLK_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clk_i |=> $stable(clk_cfg_o)); // R11
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_i |=> $stable(ctrl_o)); // R9
endmodule

// File: rtl/uart_regif.sv
// Module: UART register front end top. Decodes a 32-bit word bus into the
// data, control/status and clock words and drives the shifter handshakes.
// Assumes single-cycle bus accesses and a combinational read path.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_start,
    output logic [7:0]        tx_byte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              cts_in,
    output logic              tx_enable,
    output logic              rx_ready,
    output logic [1:0]        if_mode,
    output logic [31:0]       clk_cfg
);
    reg_sel_e           sel;
    logic               wr_data, wr_ctrl, wr_clk, rd;
    logic               tx_rdy, rx_full, ovr;
    logic [BYTE_W-1:0]  rx_held;
    ctrl_t              ctrl;

    // Address decode into a register select.
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
        else if (bus_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_CLK))  sel = SEL_CLK;
        else                                    sel = SEL_NONE;
    end

    // Write strobes and read enable.
    assign wr_data = bus_sel & bus_wr & (sel == SEL_DATA);
    assign wr_ctrl = bus_sel & bus_wr & (sel == SEL_CTRL);
    assign wr_clk  = bus_sel & bus_wr & (sel == SEL_CLK);
    assign rd      = bus_sel & ~bus_wr;

    uart_regif_txctl #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (wr_data & bus_wdata[TXR_BIT]),
        .byte_i   (bus_wdata[BYTE_W-1:0]),
        .done_i   (tx_done),
        .start_o  (tx_start),
        .byte_o   (tx_byte),
        .ready_o  (tx_rdy)
    );

    uart_regif_rxhold #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (rx_valid),
        .byte_i    (rx_byte),
        .ack_i     (wr_data & bus_wdata[RXF_BIT]),
        .ovr_clr_i (wr_ctrl & bus_wdata[OVRUN_BIT]),
        .full_o    (rx_full),
        .byte_o    (rx_held),
        .ovr_o     (ovr)
    );

    uart_regif_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_clk_i  (wr_clk),
        .wdata_i   (bus_wdata),
        .ctrl_o    (ctrl),
        .clk_cfg_o (clk_cfg)
    );

    // Handshakes after the override bits.
    assign tx_enable = ctrl.tx_ovr | cts_in;
    assign rx_ready  = ctrl.rx_ovr | ~rx_full;
    assign if_mode   = ctrl.mode;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (sel)
                SEL_DATA: begin
                    bus_rdata[BYTE_W-1:0] = rx_held;
                    bus_rdata[RXF_BIT]    = rx_full;
                    bus_rdata[TXR_BIT]    = tx_rdy;
                end
                SEL_CTRL: begin
                    bus_rdata[MODE_LO +: MODE_W] = ctrl.mode;
                    bus_rdata[TXOVR_BIT]         = ctrl.tx_ovr;
                    bus_rdata[RXOVR_BIT]         = ctrl.rx_ovr;
                    bus_rdata[OVRUN_BIT]         = ovr;
                end
                SEL_CLK:  bus_rdata = clk_cfg;
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_NO_START_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data && bus_wdata[TXR_BIT]) |=> !tx_start); // R3
    AST_UNDEF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && sel == SEL_NONE && !rx_valid) |=> ($stable(clk_cfg) && $stable(rx_full))); // R12
endmodule

// File: tb/uart_regif_tb.sv
// Bench: behavioural reference model updated on each rising edge, compared
// against every output on each falling edge.
module uart_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_start, tx_enable, rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_done = 1'b0, rx_valid = 1'b0, cts_in = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [1:0]  if_mode;
    logic [31:0] clk_cfg;

    int vecs = 0, errs = 0;
    bit done = 0;
    string cur_tag = "R1";

    // Reference state
    int m_busy = 0, m_start = 0, m_txb = 0, m_full = 0, m_rxb = 0, m_ovr = 0;
    int m_mode = 0, m_txo = 0, m_rxo = 0;
    logic [31:0] m_clk = '0;

    always #10 clk = ~clk;

    uart_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .cts_in(cts_in),
        .tx_enable(tx_enable), .rx_ready(rx_ready), .if_mode(if_mode),
        .clk_cfg(clk_cfg)
    );

    // Reference model step.
    always @(posedge clk) begin
        int wd, wc, wk, launch, ack, lost;
        if (!rst_n) begin
            m_busy = 0; m_start = 0; m_txb = 0; m_full = 0; m_rxb = 0; m_ovr = 0;
            m_mode = 0; m_txo = 0; m_rxo = 0; m_clk = '0;
        end else begin
            wd = (bus_sel && bus_wr && bus_addr == 8'h00);
            wc = (bus_sel && bus_wr && bus_addr == 8'h04);
            wk = (bus_sel && bus_wr && bus_addr == 8'h08);
            launch = wd && bus_wdata[9] && !m_busy;
            ack = wd && bus_wdata[8];
            lost = rx_valid && m_full && !ack;
            m_start = launch;
            if (launch) begin m_busy = 1; m_txb = bus_wdata[7:0]; end
            else if (tx_done) m_busy = 0;
            if (rx_valid) begin m_full = 1; m_rxb = rx_byte; end
            else if (ack) m_full = 0;
            if (lost) m_ovr = 1;
            else if (wc && bus_wdata[12]) m_ovr = 0;
            if (wc) begin m_mode = bus_wdata[3:2]; m_txo = bus_wdata[7]; m_rxo = bus_wdata[8]; end
            if (wk) m_clk = bus_wdata;
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!(bus_sel && !bus_wr)) return 32'h0;
        case (bus_addr)
            8'h00: return ((m_busy ? 0 : 1) << 9) | (m_full << 8) | m_rxb;
            8'h04: return (m_ovr << 12) | (m_rxo << 8) | (m_txo << 7) | (m_mode << 2);
            8'h08: return m_clk;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then compare all outputs.
    task automatic step(input logic sel, input logic wr, input logic [7:0] a,
                        input logic [31:0] wdv, input logic dn, input logic rv,
                        input logic [7:0] rb, input logic cts, input string tag);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wdv;
        tx_done = dn; rx_valid = rv; rx_byte = rb; cts_in = cts; cur_tag = tag;
        #1;
        chk(tag,   "rdata",     bus_rdata, exp_rdata());
        chk("R3",  "tx_start",  {31'b0, tx_start}, m_start);
        chk("R3",  "tx_byte",   {24'b0, tx_byte}, m_txb);
        chk("R10", "tx_enable", {31'b0, tx_enable}, (m_txo | cts) ? 1 : 0);
        chk("R10", "rx_ready",  {31'b0, rx_ready}, (m_rxo | !m_full) ? 1 : 0);
        chk("R9",  "if_mode",   {30'b0, if_mode}, m_mode);
        chk("R11", "clk_cfg",   clk_cfg, m_clk);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1, 0, a, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1, 1, a, d, 0, 0, 0, 0, tag);
    endtask
    task automatic idle(input logic dn, input logic rv, input logic [7:0] rb, input string tag);
        step(0, 0, 0, 0, dn, rv, rb, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rd(8'h00, "R1");                      // reset: data reads 0x200
        rd(8'h04, "R1");
        @(negedge clk); rst_n = 1'b1;
        rd(8'h00, "R1");
        rd(8'h08, "R1");
        // R11 clock word
        wr(8'h08, 32'h1234_5678, "R11");
        rd(8'h08, "R11");
        // R9 mode DCE with both overrides, then DTE without
        wr(8'h04, 32'h0000_0188, "R9");
        rd(8'h04, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
        wr(8'h04, 32'h0000_0004, "R9");
        rd(8'h04, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");  // cts drives tx_enable
        idle(0, 0, 0, "R10");
        // R3 launch byte 0x41
        wr(8'h00, 32'h0000_0241, "R3");
        rd(8'h00, "R3");                      // start pulse now, ready 0
        rd(8'h00, "R3");
        // R4 launch while busy ignored
        wr(8'h00, 32'h0000_0255, "R4");
        rd(8'h00, "R4");
        idle(1, 0, 0, "R3");                  // done
        rd(8'h00, "R3");                      // ready again
        // R5 arrival
        idle(0, 1, 8'hA5, "R5");
        rd(8'h00, "R5");
        // R8 all-zero-flag write
        wr(8'h00, 32'h0000_00FF, "R8");
        rd(8'h00, "R8");
        // R6 acknowledge
        wr(8'h00, 32'h0000_0100, "R6");
        rd(8'h00, "R6");
        // R7 overrun
        idle(0, 1, 8'h11, "R7");
        idle(0, 1, 8'h22, "R7");
        rd(8'h04, "R7");
        rd(8'h00, "R7");
        wr(8'h04, 32'h0000_0000, "R7");       // no clear without bit 12
        rd(8'h04, "R7");
        wr(8'h04, 32'h0000_1000, "R7");       // W1C
        rd(8'h04, "R7");
        // R13 arrival with simultaneous acknowledge
        step(1, 1, 8'h00, 32'h0000_0100, 0, 1, 8'h5C, 0, "R13");
        rd(8'h00, "R13");
        rd(8'h04, "R13");
        // both flags in one write
        wr(8'h00, 32'h0000_0377, "R2");
        rd(8'h00, "R2");
        idle(1, 0, 0, "R2");
        // R12 undefined offsets
        wr(8'h0C, 32'hFFFF_FFFF, "R12");
        rd(8'h0C, "R12");
        wr(8'h10, 32'h0000_0300, "R12");
        rd(8'h10, "R12");
        rd(8'h00, "R12");
        rd(8'h08, "R12");
        // Mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            string t;
            case ($urandom % 5)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C; default: a = 8'h14;
            endcase
            d = $urandom;
            t = (a == 8'h00) ? "R2" : (a == 8'h04) ? "R9" : (a == 8'h08) ? "R11" : "R12";
            step(($urandom % 4) != 0, ($urandom % 3) == 0, a, d,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, 8'($urandom), $urandom % 2, t);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule